// File: doc/BRIEF.md
# Fractional-N Division Ratio Generator

This block sets the feedback division of a fractional-N synthesizer loop. It counts cycles of the prescaled oscillator clock, gives one pulse for each completed division, and picks a new integer ratio for every division so that the long-run average ratio equals INT + FRAC/MOD. The modulus is programmable and need not be a power of two. The ratio is dithered by a third-order noise-shaping modulator. This modulator is built from three cascaded accumulators that wrap modulo MOD. Their carries are recombined so that each division adds an offset between -3 and +4 to INT.

Software presents a new integer, numerator and modulus on the configuration inputs and strobes `cfg_load`. The values are held in a staging set. They take effect at the next division boundary, and at that boundary the accumulators and carry histories are cleared. Out of reset the block runs as an integer divider at a default ratio. The configuration must satisfy INT ≥ 31, MOD ≥ 2 and FRAC < MOD.

Top module: `fracn_ratio_gen`

## Requirements
- R1: After reset `cur_ratio` equals the default integer (64), the accumulators are clear, and the first `div_pulse` is seen in the 64th clock after reset is released.
- R2: `div_pulse` is high for exactly one clock in the last clock of each division period. A period lasts `cur_ratio` clocks.
- R3: `cur_ratio` changes only on the clock edge that ends a division period, which is the edge that samples `div_pulse` high.
- R4: In fractional operation each new ratio equals the active INT plus an offset in the range -3 to +4.
- R5: While the active FRAC is zero, `cur_ratio` equals the active INT at all times.
- R6: At every period end without a pending load, the modulator steps once. Accumulator 1 adds FRAC, and accumulators 2 and 3 each add the new value of the stage before them. Each wraps modulo MOD and gives a carry c1, c2 or c3. The offset is c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where a prime marks the value from the previous step.
- R7: After k steps since the last load, the sum of the offsets minus floor(k·FRAC/MOD) lies within -1 to +2.
- R8: A `cfg_load` strobe stages the values. They become active at the first period end after the strobe, and the period that ends there keeps its old ratio. The first new ratio equals the new INT exactly, with all accumulators and histories cleared. A second strobe before that boundary replaces the staged values.
- R9: Every accumulator value stays below MOD for any modulus from 2 to 4095, including moduli that are not powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled oscillator clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_int | input | 9 | Integer part of the ratio (31 to 511) |
| cfg_frac | input | 12 | Fraction numerator (0 to MOD−1) |
| cfg_mod | input | 12 | Fraction modulus (2 to 4095) |
| cfg_load | input | 1 | One-clock strobe that stages the configuration |
| div_pulse | output | 1 | One-clock pulse per completed division |
| cur_ratio | output | 10 | Ratio of the division in progress |

## Verification
The hardest cases to reach are the extreme offsets of -3 and +4. These need the third accumulator to carry in a pattern that depends on long histories of the first two. Random moduli over the full range, including awkward non-power-of-two values, are run with random numerators for thousands of clocks each, so every carry combination occurs. Load timing is the other difficult area. Strobes are placed at random phases within a period, and in one directed case two strobes arrive back to back before a boundary. This checks that only the later values apply and that the clear happens at the boundary rather than at the strobe.

// File: rtl/nfd_pkg.sv
// Package: shared default widths and the signed offset type of the
// fractional ratio generator. Assumes a third-order modulator (offset -3..+4).
package nfd_pkg;
    localparam int NFD_INT_W  = 9;
    localparam int NFD_MOD_W  = 12;
    localparam int NFD_STAGES = 3;
    localparam int NFD_OFS_W  = 4;
    typedef logic signed [NFD_OFS_W-1:0] nfd_ofs_t;
endpackage

// File: rtl/nfd_mod_acc.sv
// First-order accumulator that wraps modulo a programmable modulus.
// Assumes add_i < mod_i and mod_i >= 2; next_o is the value after a step,
// carry_o is set when the step wraps.
module nfd_mod_acc #(
    parameter int MOD_W = nfd_pkg::NFD_MOD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [MOD_W-1:0] mod_i,
    input  logic [MOD_W-1:0] add_i,
    output logic             carry_o,
    output logic [MOD_W-1:0] next_o
);
    logic [MOD_W-1:0] acc_q;
    logic [MOD_W:0]   raw;
    logic [MOD_W:0]   wrapped;

    // Sum and wrap the candidate next value
    always_comb begin
        raw     = {1'b0, acc_q} + {1'b0, add_i};
        carry_o = (raw >= {1'b0, mod_i});
        wrapped = carry_o ? (raw - {1'b0, mod_i}) : raw;
        next_o  = wrapped[MOD_W-1:0];
    end

    // Hold the accumulator, cleared on reset or configuration apply
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= next_o;
        end
    end

    // R9: the stored value never reaches the modulus
    p_acc_below_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < mod_i);
endmodule

// File: rtl/nfd_shaper.sv
// Combines three accumulator carries through 1, (1-z^-1), (1-z^-1)^2
// into a signed offset. Histories advance on step and clear on clr.
module nfd_shaper (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [2:0]       carry_i,
    output nfd_pkg::nfd_ofs_t offset_o
);
    logic c2_d, c3_d1, c3_d2;
    logic signed [3:0] pos_sum;
    logic signed [3:0] neg_sum;

    // Form the noise-shaped offset from present and past carries
    always_comb begin
        pos_sum  = $signed({3'b0, carry_i[0]}) + $signed({3'b0, carry_i[1]})
                 + $signed({3'b0, carry_i[2]}) + $signed({3'b0, c3_d2});
        neg_sum  = $signed({3'b0, c2_d}) + $signed({2'b0, c3_d1, 1'b0});
        offset_o = pos_sum - neg_sum;
    end

    // Shift carry histories once per modulator step
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            c2_d  <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else if (step) begin
            c2_d  <= carry_i[1];
            c3_d1 <= carry_i[2];
            c3_d2 <= c3_d1;
        end
    end

    // R8: a clear leaves no carry history behind
    p_hist_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!c2_d && !c3_d1 && !c3_d2));
endmodule

// File: rtl/nfd_counter.sv
// Programmable cycle counter: terminal count flags the last clock of a
// period of ratio_i clocks. Assumes ratio_i >= 2 and changes only at tc_o.
module nfd_counter #(
    parameter int RAT_W = nfd_pkg::NFD_INT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAT_W-1:0] ratio_i,
    output logic             tc_o
);
    logic [RAT_W-1:0] cnt_q;

    // Detect the last clock of the period
    always_comb tc_o = (cnt_q == (ratio_i - 1'b1));

    // Count up, reload to zero after terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tc_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: count stays inside the period and pulses are single clocks
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_i);
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !tc_o);
endmodule

// File: rtl/fracn_ratio_gen.sv
// Fractional-N ratio generator: stages configuration, applies it at a
// period boundary, steps a third-order modulo-MOD modulator once per
// division and divides clk by INT + offset. Assumes INT >= 31, MOD >= 2,
// FRAC < MOD.
module fracn_ratio_gen #(
    parameter int INT_W   = nfd_pkg::NFD_INT_W,
    parameter int MOD_W   = nfd_pkg::NFD_MOD_W,
    parameter int RST_INT = 64,
    parameter int RST_MOD = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INT_W-1:0]   cfg_int,
    input  logic [MOD_W-1:0]   cfg_frac,
    input  logic [MOD_W-1:0]   cfg_mod,
    input  logic               cfg_load,
    output logic               div_pulse,
    output logic [INT_W:0]     cur_ratio
);
    localparam int RAT_W  = INT_W + 1;
    localparam int STAGES = nfd_pkg::NFD_STAGES;

    logic [INT_W-1:0] stage_int, act_int;
    logic [MOD_W-1:0] stage_frac, act_frac, stage_mod, act_mod;
    logic             pend_q;
    logic [RAT_W-1:0] ratio_q, ratio_next;
    logic             tc, apply, step;
    logic [STAGES-1:0] carry;
    logic [MOD_W-1:0] chain [0:STAGES];
    nfd_pkg::nfd_ofs_t offset;
    logic signed [RAT_W:0] ratio_sum;

    // Decide what the period end does
    always_comb begin
        apply = tc && pend_q;
        step  = tc && !pend_q;
    end

    // Stage configuration and remember that a load is waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_int  <= INT_W'(RST_INT);
            stage_frac <= '0;
            stage_mod  <= MOD_W'(RST_MOD);
            pend_q     <= 1'b0;
        end else begin
            if (cfg_load) begin
                stage_int  <= cfg_int;
                stage_frac <= cfg_frac;
                stage_mod  <= cfg_mod;
            end
            if (cfg_load) begin
                pend_q <= 1'b1;
            end else if (tc) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Move staged values into the active set at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_int  <= INT_W'(RST_INT);
            act_frac <= '0;
            act_mod  <= MOD_W'(RST_MOD);
        end else if (apply) begin
            act_int  <= stage_int;
            act_frac <= stage_frac;
            act_mod  <= stage_mod;
        end
    end

    assign chain[0] = act_frac;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_acc
            nfd_mod_acc #(.MOD_W(MOD_W)) u_acc (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (apply),
                .step    (step),
                .mod_i   (act_mod),
                .add_i   (chain[gi]),
                .carry_o (carry[gi]),
                .next_o  (chain[gi+1])
            );
        end
    endgenerate

    nfd_shaper u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (apply),
        .step     (step),
        .carry_i  (carry),
        .offset_o (offset)
    );

    // Add the signed offset to the active integer
    always_comb begin
        ratio_sum  = $signed({2'b0, act_int}) + $signed({{(RAT_W-3){offset[3]}}, offset});
        ratio_next = ratio_sum[RAT_W-1:0];
    end

    // Hold the ratio of the division in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RAT_W'(RST_INT);
        end else if (apply) begin
            ratio_q <= {1'b0, stage_int};
        end else if (step) begin
            ratio_q <= ratio_next;
        end
    end

    nfd_counter #(.RAT_W(RAT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio_i (ratio_q),
        .tc_o    (tc)
    );

    assign div_pulse = tc;
    assign cur_ratio = ratio_q;

    // R3: ratio is held except at a period end
    p_ratio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> $stable(ratio_q));
    // R4: ratio never strays more than the modulator range from INT
    p_offset_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (($signed({2'b0, ratio_q}) - $signed({2'b0, act_int})) >= -3) &&
        (($signed({2'b0, ratio_q}) - $signed({2'b0, act_int})) <= 4));
    // R5: a zero numerator gives a pure integer ratio
    p_integer_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_frac == '0) |-> (ratio_q == {1'b0, act_int}));
    // R8: an applied load starts with the staged integer exactly
    p_apply_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (ratio_q == {1'b0, $past(stage_int)}));
endmodule

// File: tb/sim_fracn_ratio_gen.sv
module sim_fracn_ratio_gen;
    localparam int CLK_PERIOD = 10;
    localparam int RST_INT    = 64;
    localparam int RST_MOD    = 2;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cfg_int = 9'd64;
    logic [11:0] cfg_frac = '0;
    logic [11:0] cfg_mod = 12'd2;
    logic        cfg_load = 1'b0;
    logic        div_pulse;
    logic [9:0]  cur_ratio;

    fracn_ratio_gen #(.RST_INT(RST_INT), .RST_MOD(RST_MOD)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_int(cfg_int), .cfg_frac(cfg_frac),
        .cfg_mod(cfg_mod), .cfg_load(cfg_load), .div_pulse(div_pulse),
        .cur_ratio(cur_ratio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model state, advanced at each rising edge
    int m_cnt, m_ratio, m_int, m_frac, m_mod, s_int, s_frac, s_mod;
    int a1, a2, a3, h2, h31, h32;
    bit m_pend, m_applied;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ratio = RST_INT; m_int = RST_INT; m_frac = 0; m_mod = RST_MOD;
            s_int = RST_INT; s_frac = 0; s_mod = RST_MOD; m_pend = 0; m_applied = 0;
            a1 = 0; a2 = 0; a3 = 0; h2 = 0; h31 = 0; h32 = 0;
        end else begin
            bit tc;
            int s1, s2, s3, c1, c2, c3;
            tc = (m_cnt == m_ratio - 1);
            m_applied = 0;
            m_cnt = tc ? 0 : m_cnt + 1;
            if (tc && m_pend) begin
                m_int = s_int; m_frac = s_frac; m_mod = s_mod;
                a1 = 0; a2 = 0; a3 = 0; h2 = 0; h31 = 0; h32 = 0;
                m_ratio = s_int; m_applied = 1;
            end else if (tc) begin
                s1 = a1 + m_frac; c1 = (s1 >= m_mod) ? 1 : 0; if (c1 != 0) s1 -= m_mod;
                s2 = a2 + s1;     c2 = (s2 >= m_mod) ? 1 : 0; if (c2 != 0) s2 -= m_mod;
                s3 = a3 + s2;     c3 = (s3 >= m_mod) ? 1 : 0; if (c3 != 0) s3 -= m_mod;
                a1 = s1; a2 = s2; a3 = s3;
                m_ratio = m_int + c1 + c2 - h2 + c3 - 2 * h31 + h32;
                h2 = c2; h32 = h31; h31 = c3;
            end
            if (cfg_load) begin
                s_int = cfg_int; s_frac = cfg_frac; s_mod = cfg_mod; m_pend = 1;
            end else if (tc) begin
                m_pend = 0;
            end
        end
    end

    // Per-cycle comparison, sampled away from the rising edge
    bit     prev_valid, prev_pulse;
    int     prev_ratio;
    longint d_sum, d_k;

    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            check(0, "watchdog expired", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
        if (!rst_n) begin
            prev_valid = 0; d_sum = 0; d_k = 0;
        end else begin
            check(cur_ratio == m_ratio, "R6 R9 ratio sequence", cur_ratio, m_ratio);
            check(div_pulse == (m_cnt == m_ratio - 1), "R2 pulse position",
                  div_pulse, (m_cnt == m_ratio - 1));
            if (prev_valid) begin
                if (!prev_pulse) begin
                    check(cur_ratio == prev_ratio, "R3 ratio held mid-period", cur_ratio, prev_ratio);
                end else if (m_applied) begin
                    check(cur_ratio == m_int, "R8 first ratio after load", cur_ratio, m_int);
                    d_sum = 0; d_k = 0;
                end else begin
                    longint off, fl;
                    off = longint'(cur_ratio) - m_int;
                    check(off >= -3 && off <= 4, "R4 offset range", off, 0);
                    if (m_frac == 0) check(off == 0, "R5 integer mode", off, 0);
                    d_sum += off; d_k++;
                    fl = (d_k * m_frac) / m_mod;
                    check(d_sum - fl >= -1 && d_sum - fl <= 2, "R7 cumulative offset", d_sum, fl);
                end
            end
            prev_pulse = div_pulse; prev_ratio = cur_ratio; prev_valid = 1;
        end
    end

    task automatic load(input int i, input int f, input int m);
        @(negedge clk);
        cfg_int = 9'(i); cfg_frac = 12'(f); cfg_mod = 12'(m); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        int first_pulse;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and first pulse position
        @(negedge clk);
        check(cur_ratio == RST_INT, "R1 reset ratio", cur_ratio, RST_INT);
        check(div_pulse == 1'b0, "R1 no pulse at start", div_pulse, 0);
        first_pulse = 1;
        while (!div_pulse && first_pulse < 200) begin
            @(negedge clk);
            first_pulse++;
        end
        check(first_pulse == RST_INT - 1, "R1 first pulse clock", first_pulse, RST_INT - 1);
        repeat (300) @(negedge clk);

        // Directed corners: smallest INT and MOD, largest INT and MOD
        load(31, 1, 2);      repeat (2000) @(negedge clk);
        load(511, 4094, 4095); repeat (6000) @(negedge clk);
        load(68, 101, 125);  repeat (4000) @(negedge clk);
        load(40, 0, 7);      repeat (1000) @(negedge clk);
        // R8: two strobes before one boundary, only the later applies
        load(90, 5, 9);
        load(33, 2, 3);      repeat (3000) @(negedge clk);

        // Random configurations at random phases (R9: arbitrary moduli)
        for (int n = 0; n < 20; n++) begin
            int mi, mm, mf;
            mi = 31 + int'($urandom_range(480));
            mm = 2 + int'($urandom_range(4093));
            mf = ($urandom_range(4) == 0) ? 0 : int'($urandom_range(mm - 1));
            repeat (int'($urandom_range(60))) @(negedge clk);
            load(mi, mf, mm);
            repeat (2500 + int'($urandom_range(1500))) @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule